// File: doc/BRIEF.md
# Timer-Event Converter Start Strobe Generator

This block turns events from a multi-channel timer into start requests for an analog-to-digital converter. It watches several sources: the capture/compare-A flags of each timer channel, the extra compare-E flag of channel 0, and the value and direction of a complementary-PWM counter. The PWM counter is compared against zero, which marks the trough, and against two programmable delay compare values. Each source has its own enable bit. From these sources the block produces four single-cycle request strobes.

A 2-bit trigger-select field chooses which of the four strobes becomes the converter start pulse. No start pulse is given while the converter reports that it is busy. All enables, compare values and the select field are written through a small synchronous write port. The timer counters and the converter are outside the block.

Top module: `adc_start_gen`

## Requirements
- R1: A synchronous active-low reset clears every enable bit, both delay compare values and the trigger select. While every enable is clear, no request or start pulse appears, whatever the timer inputs do.
- R2: `req_gen` pulses when the capture/compare-A flag of channel i goes high and bit i of the channel-enable register (address 0) is 1. A flag on a channel whose enable bit is 0 has no effect.
- R3: `req_gen` also pulses when `pwm_cnt` reaches 0x0000 and the trough enable (control register at address 1, bit 0) is 1. Either the R2 source or the R3 source on its own is enough to raise the request.
- R4: Every request is a one-cycle pulse. It appears in the clock cycle after the first edge at which its condition is seen true. While the condition stays true, the request does not fire again. Once the condition has been false for at least one edge, the request can fire again.
- R5: `req_ch0e` pulses when `ch0_e_flag` goes high while the channel-0 extra enable (control bit 1) is 1.
- R6: `req_dly_a` pulses when `pwm_cnt` equals the delay-A value (address 2) and the direction matches an enable. Up-count matching is enabled by control bit 2 and needs `pwm_down` = 0. Down-count matching is enabled by control bit 3 and needs `pwm_down` = 1.
- R7: `req_dly_b` follows the same rule as R6, using the delay-B value (address 3), control bit 4 for up-count and control bit 5 for down-count.
- R8: The trigger select (address 4, bits 1:0) picks the request that becomes `start_pulse`: 0 = general, 1 = channel-0 extra, 2 = delayed A, 3 = delayed B. `start_pulse` is high in the same cycle as the selected request, and other requests cause no start.
- R9: No `start_pulse` is produced for a request whose condition is sampled at an edge where `adc_busy` is high.
- R10: A write with `wr_en` high loads `wr_data` into the register at `wr_addr` at the next clock edge. The new value governs conditions from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 channel enables, 1 control, 2 delay A, 3 delay B, 4 select) |
| wr_data | input | CW (16) | Write data |
| cap_a_flag | input | NCH (5) | Capture/compare-A flags, one per channel |
| ch0_e_flag | input | 1 | Channel-0 compare-E flag |
| pwm_cnt | input | CW (16) | Complementary-PWM counter value |
| pwm_down | input | 1 | PWM counter direction, 1 = counting down |
| adc_busy | input | 1 | Converter busy |
| req_gen | output | 1 | General request pulse |
| req_ch0e | output | 1 | Channel-0 extra request pulse |
| req_dly_a | output | 1 | Delayed request A pulse |
| req_dly_b | output | 1 | Delayed request B pulse |
| start_pulse | output | 1 | Converter start strobe |

## Verification
The hardest case to reach from the ports is a delay-compare match that lands on the correct value while the counter runs in the wrong direction. It has to be told apart from a real match that follows one edge later. The stimulus first parks the counter on the compare value with only the opposite-direction enable set, and confirms that nothing fires. It then moves the counter off the value for one edge, flips the direction and comes back, which gives a clean rising condition. A second hard case is a condition held true over several edges. The bench keeps flags high across many cycles to confirm a single pulse, then drops them for one edge and raises them again to confirm the request re-arms.

// File: rtl/adc_start_gen.sv
module adc_start_gen #(
  parameter int NCH = 5,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [NCH-1:0] cap_a_flag,
  input  logic           ch0_e_flag,
  input  logic [CW-1:0]  pwm_cnt,
  input  logic           pwm_down,
  input  logic           adc_busy,
  output logic           req_gen,
  output logic           req_ch0e,
  output logic           req_dly_a,
  output logic           req_dly_b,
  output logic           start_pulse
);

  localparam logic [2:0] A_CHEN = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_DLYA = 3'd2;
  localparam logic [2:0] A_DLYB = 3'd3;
  localparam logic [2:0] A_SEL  = 3'd4;

  logic [NCH-1:0] ch_en;
  logic [5:0]     ctrl;
  logic [CW-1:0]  dly_a, dly_b;
  logic [1:0]     trig_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en    <= '0;
      ctrl     <= '0;
      dly_a    <= '0;
      dly_b    <= '0;
      trig_sel <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CHEN:  ch_en    <= wr_data[NCH-1:0];
        A_CTRL:  ctrl     <= wr_data[5:0];
        A_DLYA:  dly_a    <= wr_data;
        A_DLYB:  dly_b    <= wr_data;
        A_SEL:   trig_sel <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  wire trough_en = ctrl[0];
  wire e_en      = ctrl[1];
  wire up_a      = ctrl[2];
  wire dn_a      = ctrl[3];
  wire up_b      = ctrl[4];
  wire dn_b      = ctrl[5];

  logic [3:0] cond, cond_q, rise, req_q;

  assign cond[0] = (|(cap_a_flag & ch_en)) | (trough_en && pwm_cnt == '0);
  assign cond[1] = e_en & ch0_e_flag;
  assign cond[2] = (pwm_cnt == dly_a) & ((up_a & ~pwm_down) | (dn_a & pwm_down));
  assign cond[3] = (pwm_cnt == dly_b) & ((up_b & ~pwm_down) | (dn_b & pwm_down));
  assign rise    = cond & ~cond_q;

  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= '0;
      req_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cond_q  <= cond;
      req_q   <= rise;
      start_q <= rise[trig_sel] & ~adc_busy;
    end
  end

  assign req_gen     = req_q[0];
  assign req_ch0e    = req_q[1];
  assign req_dly_a   = req_q[2];
  assign req_dly_b   = req_q[3];
  assign start_pulse = start_q;

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (req_q == '0 && !start_pulse));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_gen |=> !req_gen);

  p_single_pulse_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_dly_a |=> !req_dly_a);

  p_dly_a_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_dly_a |-> $past(pwm_cnt == dly_a &&
                        ((up_a && !pwm_down) || (dn_a && pwm_down))));

  p_dly_b_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_dly_b |-> $past(pwm_cnt == dly_b));

  p_start_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> req_q[$past(trig_sel)]);

  p_start_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(adc_busy));

endmodule

// File: tb/test_adc_start_gen.sv
module test_adc_start_gen;
  localparam int NCH = 5;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [2:0]     wr_addr;
  logic [CW-1:0]  wr_data;
  logic [NCH-1:0] cap_a_flag;
  logic           ch0_e_flag;
  logic [CW-1:0]  pwm_cnt;
  logic           pwm_down;
  logic           adc_busy;
  logic           req_gen, req_ch0e, req_dly_a, req_dly_b, start_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  adc_start_gen #(.NCH(NCH), .CW(CW)) i_adc_start_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_a_flag(cap_a_flag), .ch0_e_flag(ch0_e_flag), .pwm_cnt(pwm_cnt),
    .pwm_down(pwm_down), .adc_busy(adc_busy), .req_gen(req_gen), .req_ch0e(req_ch0e),
    .req_dly_a(req_dly_a), .req_dly_b(req_dly_b), .start_pulse(start_pulse));

  function automatic logic [4:0] outs();
    return {req_gen, req_ch0e, req_dly_a, req_dly_b, start_pulse};
  endfunction

  task automatic expect_outs(string tag, logic [4:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: {gen,e,a,b,start} actual %b expected %b", tag, outs(), exp);
    end
  endtask

  // Sample one cycle after the stimulus, then confirm the pulse does not repeat.
  task automatic pulse_check(string tag, logic [4:0] exp);
    @(negedge clk);
    expect_outs(tag, exp);
    @(negedge clk);
    expect_outs({tag, " (no retrigger)"}, 5'b0);
  endtask

  task automatic write_reg(logic [2:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    pwm_cnt = '0; cap_a_flag = '1; ch0_e_flag = 1'b1;
    repeat (3) @(negedge clk);
    expect_outs("R1 all enables clear after reset", 5'b0);
    @(negedge clk);
    expect_outs("R1 still quiet", 5'b0);
    pwm_cnt = 16'h1234; cap_a_flag = '0; ch0_e_flag = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_general();
    write_reg(3'd0, 16'h0004);
    cap_a_flag = 5'b00010;
    pulse_check("R2 disabled channel ignored", 5'b0);
    cap_a_flag = 5'b00000;
    @(negedge clk);
    cap_a_flag = 5'b00100;
    pulse_check("R2 R8 enabled channel raises general", 5'b10001);
    repeat (3) @(negedge clk);
    expect_outs("R4 held flag no retrigger", 5'b0);
    cap_a_flag = 5'b00000;
    @(negedge clk);
    cap_a_flag = 5'b00100;
    pulse_check("R4 re-arm after falling", 5'b10001);
    cap_a_flag = 5'b00000;
    @(negedge clk);
  endtask

  task automatic t_trough();
    write_reg(3'd1, 16'h0001);
    pwm_cnt = 16'h0000;
    pulse_check("R3 trough raises general", 5'b10001);
    pwm_cnt = 16'h1234;
    @(negedge clk);
  endtask

  task automatic t_ch0e();
    write_reg(3'd1, 16'h0002);
    write_reg(3'd4, 16'h0001);
    ch0_e_flag = 1'b1;
    pulse_check("R5 R8 channel-0 extra request", 5'b01001);
    ch0_e_flag = 1'b0;
    cap_a_flag = 5'b00100;
    pulse_check("R8 unselected general gives no start", 5'b10000);
    cap_a_flag = 5'b00000;
    @(negedge clk);
  endtask

  task automatic t_delay_a();
    write_reg(3'd2, 16'h0040);
    write_reg(3'd1, 16'h0004);
    write_reg(3'd4, 16'h0002);
    pwm_down = 1'b1; pwm_cnt = 16'h0040;
    pulse_check("R6 up-enable ignores down-count match", 5'b0);
    pwm_cnt = 16'h0041;
    @(negedge clk);
    pwm_down = 1'b0; pwm_cnt = 16'h0040;
    pulse_check("R6 up-count match", 5'b00101);
    pwm_cnt = 16'h1234;
    write_reg(3'd1, 16'h0008);
    pwm_down = 1'b1; pwm_cnt = 16'h0040;
    pulse_check("R6 down-count match", 5'b00101);
    pwm_cnt = 16'h0041;
    @(negedge clk);
    pwm_down = 1'b0; pwm_cnt = 16'h0040;
    pulse_check("R6 down-enable ignores up-count match", 5'b0);
    pwm_cnt = 16'h1234;
    @(negedge clk);
  endtask

  task automatic t_delay_b();
    write_reg(3'd3, 16'h0100);
    write_reg(3'd1, 16'h0030);
    write_reg(3'd4, 16'h0003);
    pwm_down = 1'b0; pwm_cnt = 16'h0100;
    pulse_check("R7 R10 delay B up-count", 5'b00011);
    pwm_cnt = 16'h1234;
    @(negedge clk);
    pwm_down = 1'b1; pwm_cnt = 16'h0100;
    pulse_check("R7 delay B down-count", 5'b00011);
    pwm_cnt = 16'h1234; pwm_down = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_busy();
    write_reg(3'd4, 16'h0000);
    adc_busy = 1'b1;
    cap_a_flag = 5'b00100;
    pulse_check("R9 busy suppresses start", 5'b10000);
    cap_a_flag = 5'b00000;
    adc_busy = 1'b0;
    @(negedge clk);
    cap_a_flag = 5'b00100;
    pulse_check("R9 start returns when idle", 5'b10001);
    cap_a_flag = 5'b00000;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cap_a_flag = '0; ch0_e_flag = 1'b0; pwm_cnt = 16'h1234;
    pwm_down = 1'b0; adc_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_general();
    t_trough();
    t_ch0e();
    t_delay_a();
    t_delay_b();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule